// File: doc/BRIEF.md
# Multiplexed-Address DRAM Front End

This block is the digital front end of an asynchronous 4-bit-wide dynamic memory. It is modelled with a free-running oversampling clock. The active-low row strobe, column strobe, write enable and output enable are synchronised to that clock. Their edges are found by comparing each synchronised strobe with its value one cycle earlier. A row is captured from the shared address pins when the row strobe falls. A column is captured on every fall of the column strobe, so one open row can serve many column accesses (page mode).

When the column strobe is already low as the row strobe falls, the cycle is a refresh that takes its row from an internal auto-incrementing counter. A row strobe cycle with no column strobe refreshes the row on the address pins. Each refresh, and each row opening, is reported to the storage core by a one-cycle pulse together with the row number. Writes are either early writes or read-modify-writes. The storage array is a small behavioural memory indexed by the low bits of row and column.

Top module: `dram_front_end`

## Requirements
- R1: A fall of `ras_ni` latches the row from `addr_i`. One cycle after the fall is acted on, `rfsh_o` pulses high for exactly one cycle with that row on `rfsh_row_o`.
- R2: Each fall of `cas_ni` inside an open row latches the column from `addr_i`. With `we_ni` low at that fall, `data_i` is written to the row and column (early write). With `we_ni` high, the stored nibble is read.
- R3: If `cas_ni` is low when `ras_ni` falls, the row comes from an 11-bit refresh counter and not from `addr_i`, and `rfsh_row_o` shows the counter value. The counter then advances by one and wraps from 2047 to 0.
- R4: While `ras_ni` stays low, successive column strobes access different columns of the same latched row.
- R5: `data_oe_o` is high only during a read access while `cas_ni` and `oe_ni` are both low. It drops when either strobe goes high, and `data_o` is zero whenever `data_oe_o` is low.
- R6: A row-strobe-only cycle raises `rfsh_o` with the pin row, does not advance the counter and never raises `data_oe_o`.
- R7: If `we_ni` falls while `cas_ni` is still low after a read, `data_i` is stored at the row and column of that read.
- R8: After `rst_ni` is released, `data_o`, `data_oe_o`, `rfsh_o` and `rfsh_row_o` are zero, and the first counter refresh uses row 0.
- R9: A counter refresh cycle performs no data access. No write happens even with `we_ni` low, and `data_oe_o` stays low.
- R10: An early write cycle never raises `data_oe_o`, even with `oe_ni` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Oversampling model clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ras_ni | input | 1 | Row strobe, active low |
| cas_ni | input | 1 | Column strobe, active low |
| we_ni | input | 1 | Write enable, active low |
| oe_ni | input | 1 | Output enable, active low |
| addr_i | input | 11 | Shared row/column address |
| data_i | input | 4 | Write data |
| data_o | output | 4 | Read data, zero when not driven |
| data_oe_o | output | 1 | Data output driver enable |
| rfsh_o | output | 1 | One-cycle row activation/refresh pulse |
| rfsh_row_o | output | 11 | Row being activated or refreshed |

## Verification
The assertions watch, on every cycle, the refresh counter's step on a counter refresh and its stability otherwise. They also check that the reported refresh row matches the counter, that the activation pulse lasts a single cycle, that no write happens during a counter refresh, and that the output driver is off while the row strobe is high. Only the bench scenarios can show that stored data returns correctly across early write, page mode and read-modify-write. The same holds for the pin row being used by row-strobe-only cycles and for the counter wrapping after 2048 refreshes.

// File: rtl/dram_fe_pkg.sv
`timescale 1ns/1ps
package dram_fe_pkg;
  localparam int unsigned ADDR_W = 11;
  localparam int unsigned DATA_W = 4;

  typedef struct packed {
    logic ras_n;
    logic cas_n;
    logic we_n;
    logic oe_n;
  } strobe_t;
endpackage

// File: rtl/dram_sync.sv
`timescale 1ns/1ps
module dram_sync #(
  parameter int unsigned W       = 4,
  parameter int unsigned STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] pipe [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < STAGES; i++) pipe[i] <= RST_VAL;
    end else begin
      pipe[0] <= d_i;
      for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
    end
  end

  assign q_o = pipe[STAGES-1];
endmodule

// File: rtl/dram_refresh_ctr.sv
`timescale 1ns/1ps
module dram_refresh_ctr #(
  parameter int unsigned W = 11
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         adv_i,
  output logic [W-1:0] cnt_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_o <= '0;
    else if (adv_i) cnt_o <= cnt_o + 1'b1;  // natural wrap over 2^W rows
  end
endmodule

// File: rtl/dram_cell_array.sv
`timescale 1ns/1ps
module dram_cell_array #(
  parameter int unsigned DATA_W    = 4,
  parameter int unsigned MEM_ROW_W = 3,
  parameter int unsigned MEM_COL_W = 4,
  localparam int unsigned IDX_W    = MEM_ROW_W + MEM_COL_W,
  localparam int unsigned DEPTH    = 1 << IDX_W
) (
  input  logic                 clk_i,
  input  logic                 we_i,
  input  logic [MEM_ROW_W-1:0] row_i,
  input  logic [MEM_COL_W-1:0] col_i,
  input  logic [DATA_W-1:0]    wdata_i,
  output logic [DATA_W-1:0]    rdata_o
);
  logic [DATA_W-1:0] mem [DEPTH];
  logic [IDX_W-1:0]  idx;

  assign idx     = {row_i, col_i};
  assign rdata_o = mem[idx];

  always_ff @(posedge clk_i) begin
    if (we_i) mem[idx] <= wdata_i;
  end
endmodule

// File: rtl/dram_front_end.sv
`timescale 1ns/1ps
module dram_front_end
  import dram_fe_pkg::*;
#(
  parameter int unsigned ADDR_BITS   = ADDR_W,
  parameter int unsigned DATA_BITS   = DATA_W,
  parameter int unsigned MEM_ROW_W   = 3,
  parameter int unsigned MEM_COL_W   = 4,
  parameter int unsigned SYNC_STAGES = 2,
  localparam int unsigned PAY_W      = ADDR_BITS + DATA_BITS
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 ras_ni,
  input  logic                 cas_ni,
  input  logic                 we_ni,
  input  logic                 oe_ni,
  input  logic [ADDR_BITS-1:0] addr_i,
  input  logic [DATA_BITS-1:0] data_i,
  output logic [DATA_BITS-1:0] data_o,
  output logic                 data_oe_o,
  output logic                 rfsh_o,
  output logic [ADDR_BITS-1:0] rfsh_row_o
);
  strobe_t strb_s, strb_p;
  logic [PAY_W-1:0] pay_s;
  logic [ADDR_BITS-1:0] addr_s;
  logic [DATA_BITS-1:0] data_s;

  // strobes and payload share one latency so addresses line up with edges
  dram_sync #(.W(4), .STAGES(SYNC_STAGES), .RST_VAL(4'hF)) strb_sync_u (
    .clk_i, .rst_ni, .d_i({ras_ni, cas_ni, we_ni, oe_ni}), .q_o(strb_s));
  dram_sync #(.W(PAY_W), .STAGES(SYNC_STAGES), .RST_VAL('0)) pay_sync_u (
    .clk_i, .rst_ni, .d_i({addr_i, data_i}), .q_o(pay_s));

  assign {addr_s, data_s} = pay_s;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) strb_p <= '1;
    else         strb_p <= strb_s;
  end

  logic ras_s, cas_s, oe_s;
  logic ras_fall, ras_rise, cas_fall, cas_rise, we_fall, cbr_start;
  assign ras_s     = strb_s.ras_n;
  assign cas_s     = strb_s.cas_n;
  assign oe_s      = strb_s.oe_n;
  assign ras_fall  = strb_p.ras_n & ~strb_s.ras_n;
  assign ras_rise  = ~strb_p.ras_n & strb_s.ras_n;
  assign cas_fall  = strb_p.cas_n & ~strb_s.cas_n;
  assign cas_rise  = ~strb_p.cas_n & strb_s.cas_n;
  assign we_fall   = strb_p.we_n & ~strb_s.we_n;
  assign cbr_start = ras_fall & ~strb_s.cas_n;

  logic [ADDR_BITS-1:0] rcnt;
  dram_refresh_ctr #(.W(ADDR_BITS)) rfsh_ctr_u (
    .clk_i, .rst_ni, .adv_i(cbr_start), .cnt_o(rcnt));

  logic [ADDR_BITS-1:0] row_q;
  logic [MEM_COL_W-1:0] col_q;
  logic row_open_q, cbr_q, col_act_q, early_wr_q;
  logic [DATA_BITS-1:0] rd_q;

  logic col_go, mem_we;
  logic [MEM_COL_W-1:0] mem_col;
  logic [DATA_BITS-1:0] mem_rdata;

  assign col_go  = cas_fall & row_open_q & ~ras_fall & ~ras_rise;
  assign mem_col = col_go ? addr_s[MEM_COL_W-1:0] : col_q;
  // early write at column fall, or late write (read-modify-write) on WE fall
  assign mem_we  = (col_go & ~strb_s.we_n)
                 | (we_fall & col_act_q & ~early_wr_q & ~cas_s & ~cas_rise);

  dram_cell_array #(.DATA_W(DATA_BITS), .MEM_ROW_W(MEM_ROW_W), .MEM_COL_W(MEM_COL_W)) array_u (
    .clk_i, .we_i(mem_we), .row_i(row_q[MEM_ROW_W-1:0]), .col_i(mem_col),
    .wdata_i(data_s), .rdata_o(mem_rdata));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      row_q      <= '0;
      col_q      <= '0;
      row_open_q <= 1'b0;
      cbr_q      <= 1'b0;
      col_act_q  <= 1'b0;
      early_wr_q <= 1'b0;
      rd_q       <= '0;
      rfsh_o     <= 1'b0;
      rfsh_row_o <= '0;
    end else begin
      rfsh_o <= ras_fall;
      if (ras_fall) begin
        row_q      <= cbr_start ? rcnt : addr_s;
        rfsh_row_o <= cbr_start ? rcnt : addr_s;
        row_open_q <= ~cbr_start;
        cbr_q      <= cbr_start;
        col_act_q  <= 1'b0;
      end else if (ras_rise) begin
        row_open_q <= 1'b0;
        cbr_q      <= 1'b0;
        col_act_q  <= 1'b0;
      end else if (col_go) begin
        col_q      <= addr_s[MEM_COL_W-1:0];
        col_act_q  <= 1'b1;
        early_wr_q <= ~strb_s.we_n;
        rd_q       <= mem_rdata;
      end else if (cas_rise) begin
        col_act_q  <= 1'b0;
      end
    end
  end

  assign data_oe_o = col_act_q & ~early_wr_q & ~oe_s & ~cas_s;
  assign data_o    = data_oe_o ? rd_q : '0;
endmodule

// File: rtl/dram_front_end_chk.sv
`timescale 1ns/1ps
module dram_front_end_chk #(
  parameter int unsigned ADDR_BITS = 11
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 ras_s,
  input logic                 cbr_start,
  input logic                 cbr_q,
  input logic                 mem_we,
  input logic [ADDR_BITS-1:0] rcnt,
  input logic                 rfsh_o,
  input logic [ADDR_BITS-1:0] rfsh_row_o,
  input logic                 data_oe_o
);
  AST_CBR_ADVANCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cbr_start |=> rcnt == ADDR_BITS'($past(rcnt) + 1'b1));  // R3
  AST_CNT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cbr_start |=> $stable(rcnt));  // R6
  AST_CBR_ROW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cbr_start |=> rfsh_o && rfsh_row_o == $past(rcnt));  // R3
  AST_PULSE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rfsh_o |=> !rfsh_o);  // R1
  AST_CBR_NO_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cbr_q |-> !mem_we);  // R9
  AST_NO_DRIVE_ROW_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ras_s && $past(ras_s)) |-> !data_oe_o);  // R5
endmodule

bind dram_front_end dram_front_end_chk #(.ADDR_BITS(ADDR_BITS)) chk_u (
  .clk_i(clk_i), .rst_ni(rst_ni), .ras_s(ras_s), .cbr_start(cbr_start),
  .cbr_q(cbr_q), .mem_we(mem_we), .rcnt(rcnt), .rfsh_o(rfsh_o),
  .rfsh_row_o(rfsh_row_o), .data_oe_o(data_oe_o));

// File: tb/dram_front_end_test.sv
`timescale 1ns/1ps
module dram_front_end_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
  logic [10:0] addr = '0;
  logic [3:0]  din = '0;
  logic [3:0]  dout;
  logic        doe, rfsh;
  logic [10:0] rfsh_row;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  dram_front_end uut (
    .clk_i(clk), .rst_ni(rst_n), .ras_ni(ras_n), .cas_ni(cas_n),
    .we_ni(we_n), .oe_ni(oe_n), .addr_i(addr), .data_i(din),
    .data_o(dout), .data_oe_o(doe), .rfsh_o(rfsh), .rfsh_row_o(rfsh_row));

  // capture refresh pulses at the ports
  int rf_cnt = 0;
  logic [10:0] rf_row = '0;
  always @(posedge clk) if (rfsh) begin rf_cnt <= rf_cnt + 1; rf_row <= rfsh_row; end

  logic [3:0] shadow [int];

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic row_open(input logic [10:0] r);
    addr = r; tick(1); ras_n = 1'b0; tick(4);
  endtask

  task automatic row_close();
    cas_n = 1'b1; we_n = 1'b1; tick(1); ras_n = 1'b1; tick(4);
  endtask

  task automatic col_write(input logic [10:0] r, input logic [10:0] c, input logic [3:0] d);
    addr = c; din = d; we_n = 1'b0; oe_n = 1'b0; tick(1);
    cas_n = 1'b0; tick(4);
    chk("R10 early write no drive", 16'(doe), 16'd0);
    cas_n = 1'b1; we_n = 1'b1; oe_n = 1'b1; tick(4);
    shadow[int'(r) * 2048 + int'(c)] = d;
  endtask

  task automatic col_read(input logic [10:0] r, input logic [10:0] c, input string req);
    addr = c; we_n = 1'b1; oe_n = 1'b0; tick(1);
    cas_n = 1'b0; tick(4);
    chk(req, {11'd0, doe, dout}, {11'd0, 1'b1, shadow[int'(r) * 2048 + int'(c)]});
    cas_n = 1'b1; tick(4); oe_n = 1'b1;
  endtask

  task automatic cbr(input logic [3:0] wd);
    we_n = 1'b0; din = wd; oe_n = 1'b0;
    cas_n = 1'b0; tick(3); ras_n = 1'b0; tick(4);
    ras_n = 1'b1; tick(1); cas_n = 1'b1; we_n = 1'b1; oe_n = 1'b1; tick(3);
  endtask

  // {write, row[10:0], col[10:0], data[3:0]}
  localparam logic [26:0] VEC [8] = '{
    {1'b1, 11'd1, 11'd2, 4'h3},
    {1'b1, 11'd2, 11'd3, 4'hC},
    {1'b1, 11'd1, 11'd3, 4'h5},
    {1'b1, 11'd3, 11'd15, 4'hA},
    {1'b0, 11'd1, 11'd2, 4'h0},
    {1'b0, 11'd2, 11'd3, 4'h0},
    {1'b0, 11'd3, 11'd15, 4'h0},
    {1'b0, 11'd1, 11'd3, 4'h0}
  };

  initial begin
    #1_500_000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int base;
    tick(3); rst_n = 1'b1; tick(3);
    // R8: reset state
    chk("R8 reset outputs", {doe, rfsh, dout, rfsh_row}, 16'd0);

    // R2: table of single-access cycles
    foreach (VEC[i]) begin
      row_open(VEC[i][25:15]);
      if (VEC[i][26]) col_write(VEC[i][25:15], VEC[i][14:4], VEC[i][3:0]);
      else            col_read(VEC[i][25:15], VEC[i][14:4], "R2 table read");
      row_close();
    end

    // R4: page mode, several columns under one row
    row_open(11'd5);
    col_write(11'd5, 11'd1, 4'h7);
    col_write(11'd5, 11'd2, 4'h8);
    col_write(11'd5, 11'd9, 4'h9);
    col_read(11'd5, 11'd2, "R4 page read col2");
    col_read(11'd5, 11'd1, "R4 page read col1");
    col_read(11'd5, 11'd9, "R4 page read col9");
    row_close();
    row_open(11'd6); col_write(11'd6, 11'd2, 4'h1); row_close();
    row_open(11'd5); col_read(11'd5, 11'd2, "R4 row kept apart"); row_close();

    // R1/R6: row-strobe-only cycle
    base = rf_cnt;
    oe_n = 1'b0;
    row_open(11'h123);
    chk("R6 no drive", 16'(doe), 16'd0);
    row_close(); oe_n = 1'b1;
    chk("R1 pin row reported", 16'(rf_row), 16'h123);
    chk("R1 one pulse", 16'(rf_cnt - base), 16'd1);

    // R3/R8/R9: counter refreshes start at row 0 and ignore pins
    addr = 11'd5;
    cbr(4'hF);
    chk("R8 first counter row", 16'(rf_row), 16'd0);
    cbr(4'hF);
    chk("R3 counter row 1", 16'(rf_row), 16'd1);
    row_open(11'd5); col_read(11'd5, 11'd1, "R9 refresh wrote nothing"); row_close();
    cbr(4'hE);
    chk("R3 counter row 2 (pin row ignored)", 16'(rf_row), 16'd2);

    // R5: output enable gating
    row_open(11'd5);
    addr = 11'd9; we_n = 1'b1; oe_n = 1'b1; tick(1); cas_n = 1'b0; tick(4);
    chk("R5 OE high no drive", {11'd0, doe, dout}, 16'd0);
    oe_n = 1'b0; tick(4);
    chk("R5 OE low drives", {11'd0, doe, dout}, 16'h19);
    cas_n = 1'b1; tick(4);
    chk("R5 CAS high releases", {11'd0, doe, dout}, 16'd0);
    oe_n = 1'b1;
    row_close();

    // R7: read-modify-write
    row_open(11'd7);
    col_write(11'd7, 11'd4, 4'h2);
    addr = 11'd4; we_n = 1'b1; oe_n = 1'b0; tick(1); cas_n = 1'b0; tick(4);
    chk("R7 read phase", {11'd0, doe, dout}, 16'h12);
    din = 4'hB; we_n = 1'b0; tick(4);
    cas_n = 1'b1; we_n = 1'b1; oe_n = 1'b1; tick(4);
    shadow[7 * 2048 + 4] = 4'hB;
    col_read(11'd7, 11'd4, "R7 modified value");
    row_close();

    // R3: wrap of the counter
    for (int k = 3; k < 2047; k++) cbr(4'h0);
    cbr(4'h0);
    chk("R3 counter row 2047", 16'(rf_row), 16'd2047);
    cbr(4'h0);
    chk("R3 counter wraps to 0", 16'(rf_row), 16'd0);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule